// File: doc/BRIEF.md
# Codec Mode-Change Register Write Gate

This block holds the configuration registers of an audio codec behind a single host write port. Each field has a gate, and the gate decides whether a write reaches that field. A global mode-change bit opens the interface configuration field and the sample-rate select. The playback data-format field opens when either the global bit or a playback mode-change bit is set. The capture data-format field opens when either the global bit or a capture mode-change bit is set. A write to a field whose gate is closed is dropped without any indication, and the field keeps its old value.

The playback and capture enable bits are handled differently. A host may write them at any time, and the new value is stored in a pending register. The pending value is copied to the effective enable bits only on a clock edge at which the DMA-outstanding flag is low, so the enables never change while a transfer is still in flight. The outputs always show the effective contents of the registers and never the pending values. The write port is a plain strobe. It has no back-pressure, and the block accepts a write on every cycle.

Top module: `cmw_reg_gate`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, every output register reads 0.
- R2: Address 0 holds the global mode-change bit in bit 0. Address 4 holds the playback mode-change bit in bit 0 and the capture mode-change bit in bit 1. Both registers accept writes at any time, and their other bits read 0.
- R3: Bits 7:2 of the interface register (address 1) take a write only while the global mode-change bit is 1. Otherwise they keep their value.
- R4: Bits 3:0 of the playback format register (address 2), the sample-rate select, take a write only while the global mode-change bit is 1.
- R5: Bits 7:4 of the playback format register take a write while the global bit or the playback mode-change bit is 1.
- R6: Bits 7:4 of the capture format register (address 3) take a write while the global bit or the capture mode-change bit is 1. Bits 3:0 of this register always read 0.
- R7: Bits 1:0 of the interface register are the playback enable (bit 0) and the capture enable (bit 1). A write to address 1 stores data bits 1:0 as the pending enables, whatever the state of the mode-change bits.
- R8: The effective enables, shown on iface_reg[1:0], take the pending value at every clock edge at which dma_busy is low, and they hold while dma_busy is high. A write at edge N therefore appears at edge N+1 at the earliest.
- R9: A write to an address other than 0 to 4 changes no output.
- R10: A cycle with wr_en low changes no register, whatever is on wr_addr and wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| dma_busy | input | 1 | High while any DMA transfer is outstanding |
| mode_reg | output | 8 | Global mode-change register |
| alt_mce_reg | output | 8 | Playback and capture mode-change register |
| iface_reg | output | 8 | Interface configuration with the effective enables |
| play_fmt | output | 8 | Playback format: data format and rate select |
| cap_fmt | output | 8 | Capture format |

## Verification
The assertions assume that wr_en, wr_addr, wr_data and dma_busy hold known values at every rising edge after reset, and that the gate state sampled at an edge is the state that was written at earlier edges. The bench changes every input only at the falling edge and pulses wr_en for exactly one cycle per write. It holds dma_busy steady across the windows it checks, and it moves dma_busy only at a falling edge, so each commit edge is known in advance.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
  localparam int ADDR_MODE  = 0;
  localparam int ADDR_IFACE = 1;
  localparam int ADDR_PLAY  = 2;
  localparam int ADDR_CAP   = 3;
  localparam int ADDR_ALT   = 4;
  localparam int NUM_EN     = 2;  // playback, capture enables
endpackage

// File: rtl/cmw_field_gate.sv
module cmw_field_gate #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          q <= '0;
    else if (hit && open) q <= d;
  end

  p_closed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && open) |=> $stable(q));
endmodule

// File: rtl/cmw_enable_commit.sv
module cmw_enable_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic d,
  input  logic dma_busy,
  output logic eff
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      eff     <= 1'b0;
    end else begin
      if (hit)       pending <= d;
      if (!dma_busy) eff     <= pending;
    end
  end

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |=> $stable(eff));
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !dma_busy) |=> ##1 ($past(dma_busy) || eff == $past(d, 2)));
endmodule

// File: rtl/cmw_reg_gate.sv
module cmw_reg_gate #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          dma_busy,
  output logic [DW-1:0] mode_reg,
  output logic [DW-1:0] alt_mce_reg,
  output logic [DW-1:0] iface_reg,
  output logic [DW-1:0] play_fmt,
  output logic [DW-1:0] cap_fmt
);
  import cmw_pkg::*;

  localparam int HW = DW / 2;
  localparam int CW = DW - NUM_EN;

  logic hit_mode, hit_iface, hit_play, hit_cap, hit_alt;
  logic g_mce;
  logic [1:0] alt_q;
  logic [CW-1:0] cfg_q;
  logic [HW-1:0] rate_q, pfmt_q, cfmt_q;
  logic [NUM_EN-1:0] en_eff;

  assign hit_mode  = wr_en && (wr_addr == AW'(ADDR_MODE));
  assign hit_iface = wr_en && (wr_addr == AW'(ADDR_IFACE));
  assign hit_play  = wr_en && (wr_addr == AW'(ADDR_PLAY));
  assign hit_cap   = wr_en && (wr_addr == AW'(ADDR_CAP));
  assign hit_alt   = wr_en && (wr_addr == AW'(ADDR_ALT));

  cmw_field_gate #(.W(1)) u_mode (
    .clk(clk), .rst_n(rst_n), .hit(hit_mode), .open(1'b1),
    .d(wr_data[0]), .q(g_mce));

  cmw_field_gate #(.W(2)) u_alt (
    .clk(clk), .rst_n(rst_n), .hit(hit_alt), .open(1'b1),
    .d(wr_data[1:0]), .q(alt_q));

  cmw_field_gate #(.W(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .hit(hit_iface), .open(g_mce),
    .d(wr_data[DW-1:NUM_EN]), .q(cfg_q));

  cmw_field_gate #(.W(HW)) u_rate (
    .clk(clk), .rst_n(rst_n), .hit(hit_play), .open(g_mce),
    .d(wr_data[HW-1:0]), .q(rate_q));

  cmw_field_gate #(.W(HW)) u_pfmt (
    .clk(clk), .rst_n(rst_n), .hit(hit_play), .open(g_mce || alt_q[0]),
    .d(wr_data[DW-1:HW]), .q(pfmt_q));

  cmw_field_gate #(.W(HW)) u_cfmt (
    .clk(clk), .rst_n(rst_n), .hit(hit_cap), .open(g_mce || alt_q[1]),
    .d(wr_data[DW-1:HW]), .q(cfmt_q));

  for (genvar i = 0; i < NUM_EN; i++) begin : g_en
    cmw_enable_commit u_commit (
      .clk(clk), .rst_n(rst_n), .hit(hit_iface), .d(wr_data[i]),
      .dma_busy(dma_busy), .eff(en_eff[i]));
  end

  assign mode_reg    = {{(DW-1){1'b0}}, g_mce};
  assign alt_mce_reg = {{(DW-2){1'b0}}, alt_q};
  assign iface_reg   = {cfg_q, en_eff};
  assign play_fmt    = {pfmt_q, rate_q};
  assign cap_fmt     = {cfmt_q, {HW{1'b0}}};

  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_IFACE) && !mode_reg[0])
      |=> iface_reg[DW-1:NUM_EN] == $past(iface_reg[DW-1:NUM_EN]));
  p_rate_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_PLAY) && !mode_reg[0])
      |=> play_fmt[HW-1:0] == $past(play_fmt[HW-1:0]));
  p_pfmt_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_PLAY) && !mode_reg[0] && !alt_mce_reg[0])
      |=> play_fmt[DW-1:HW] == $past(play_fmt[DW-1:HW]));
  p_cfmt_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(ADDR_CAP) && !mode_reg[0] && !alt_mce_reg[1])
      |=> cap_fmt == $past(cap_fmt));
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && dma_busy) |=> ($stable(mode_reg) && $stable(play_fmt) &&
                              $stable(cap_fmt) && $stable(alt_mce_reg)));
endmodule

// File: tb/cmw_reg_gate_tb.sv
module cmw_reg_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       dma_busy = 1'b0;
  logic [7:0] mode_reg, alt_mce_reg, iface_reg, play_fmt, cap_fmt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  cmw_reg_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dma_busy(dma_busy), .mode_reg(mode_reg),
    .alt_mce_reg(alt_mce_reg), .iface_reg(iface_reg),
    .play_fmt(play_fmt), .cap_fmt(cap_fmt));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 mode", mode_reg, 8'h00);
    check("R1 alt", alt_mce_reg, 8'h00);
    check("R1 iface", iface_reg, 8'h00);
    check("R1 play", play_fmt, 8'h00);
    check("R1 cap", cap_fmt, 8'h00);
  endtask

  task automatic t_mode_regs();
    wr(3'd0, 8'hFF);
    check("R2 mode bit", mode_reg, 8'h01);
    wr(3'd4, 8'hFF);
    check("R2 alt bits", alt_mce_reg, 8'h03);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    check("R2 clear", alt_mce_reg | mode_reg, 8'h00);
  endtask

  task automatic t_closed();
    wr(3'd1, 8'hFC);
    check("R3 cfg locked", iface_reg, 8'h00);
    wr(3'd2, 8'hFF);
    check("R4 R5 play locked", play_fmt, 8'h00);
    wr(3'd3, 8'hF0);
    check("R6 cap locked", cap_fmt, 8'h00);
  endtask

  task automatic t_side_mce();
    wr(3'd4, 8'h01);
    wr(3'd2, 8'hA5);
    check("R5 R4 play fmt only", play_fmt, 8'hA0);
    wr(3'd3, 8'hB0);
    check("R6 cap needs own bit", cap_fmt, 8'h00);
    wr(3'd4, 8'h02);
    wr(3'd3, 8'hBF);
    check("R6 cap fmt low zero", cap_fmt, 8'hB0);
    wr(3'd2, 8'h55);
    check("R5 play closed again", play_fmt, 8'hA0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_global();
    wr(3'd0, 8'h01);
    wr(3'd1, 8'hA8);
    check("R3 cfg open", iface_reg, 8'hA8);
    wr(3'd2, 8'h3C);
    check("R4 rate open", play_fmt, 8'h3C);
    wr(3'd3, 8'h70);
    check("R6 global opens cap", cap_fmt, 8'h70);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_enables();
    @(negedge clk); dma_busy = 1'b1;
    wr(3'd1, 8'h03);
    check("R7 R3 cfg kept, en held", iface_reg, 8'hA8);
    idle(3);
    check("R8 held while busy", iface_reg, 8'hA8);
    dma_busy = 1'b0;
    @(negedge clk);
    check("R8 commit after drain", iface_reg, 8'hAB);
    wr(3'd1, 8'h00);
    check("R8 one edge later", iface_reg, 8'hAB);
    @(negedge clk);
    check("R8 committed", iface_reg, 8'hA8);
  endtask

  task automatic t_ignored();
    wr(3'd7, 8'hFF);
    check("R9 iface", iface_reg, 8'hA8);
    check("R9 mode", mode_reg, 8'h00);
    check("R9 play", play_fmt, 8'h3C);
    wr(3'd0, 8'h01);
    @(negedge clk);
    wr_addr = 3'd2; wr_data = 8'hFF; wr_en = 1'b0;
    idle(2);
    check("R10 no strobe", play_fmt, 8'h3C);
    wr(3'd0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_regs();
    t_closed();
    t_side_mce();
    t_global();
    t_enables();
    t_ignored();
    finish_run();
  end
endmodule